// File: doc/BRIEF.md
# Sensor Node Power Mode Sequencer

This block steers the power states of a battery-powered sensing node through one duty-cycled round. A round gathers a fixed block of samples, hands the processor a period of full-speed work, sends the result over the radio and then drops every subsystem into its lowest state. The per-subsystem controls are the processor mode, the analog supply, the anti-aliasing prefilter, the converter, the radio supply, the RF synthesizer, the transmitter and the receiver. Each control has its own encoding rather than one shared on/off flag.

While samples are being gathered, each sample-rate tick produces a one-cycle capture strobe and wakes the processor. The processor drops back to idle once it acknowledges that it has serviced the sample. After the work phase, the synthesizer is started a programmable number of cycles ahead of the transmitter, which covers the time its loop needs to lock. The transmit amplifier level is latched from one of six steps. An abort input sends the whole node to sleep on the next clock.

Top module: `node_power_seq`

## Requirements
- R1: After reset, and whenever the node is asleep, proc_mode_o is 0 (sleep), every enable and power output is 0, pa_level_o is 0 and sample_strobe_o is 0.
- R2: A wake_i pulse while asleep starts gathering on the next cycle: afe_pwr_o, prefilt_active_o and adc_active_o are 1, proc_mode_o is 1 (idle), and the radio outputs are 0. A wake_i pulse in any other phase has no effect.
- R3: During gathering, each tick_i gives sample_strobe_o = 1 for one cycle, and proc_mode_o = 2 (active), on the cycle after the tick.
- R4: During gathering, svc_ack_i returns proc_mode_o to 1 (idle) on the next cycle.
- R5: Gathering ends on exactly the SAMPLES-th tick (default 1024). On the next cycle the work phase begins: proc_mode_o is 2 (active) for the whole phase, the analog outputs are 0 and tx_en_o is 0.
- R6: tick_i outside gathering is ignored: it gives no strobe and does not count toward a round.
- R7: When comp_done_i arrives with warm_cycles_i = N > 0, radio_pwr_o and synth_active_o are 1 and tx_en_o is 0 for exactly N cycles before tx_en_o rises. With N = 0, the transmitter is enabled directly.
- R8: While transmitting, tx_en_o, radio_pwr_o and synth_active_o are 1 and proc_mode_o is 1 (idle). pa_level_o holds pa_level_i as sampled with comp_done_i, clamped to the range 0..5 (5 is the top step). pa_level_o is 0 in every other phase.
- R9: tx_done_i during transmission puts the node to sleep on the next cycle, with the outputs listed in R1.
- R10: abort_i in any phase gives the sleep outputs of R1 on the next cycle. The next round needs a full SAMPLES ticks again.
- R11: rx_en_o stays 0 in every phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_i | input | 1 | Start a round from sleep |
| abort_i | input | 1 | Force the whole node to sleep |
| tick_i | input | 1 | Sample-rate tick |
| svc_ack_i | input | 1 | Processor has serviced the sample |
| comp_done_i | input | 1 | Work phase finished |
| tx_done_i | input | 1 | Transmission finished |
| warm_cycles_i | input | WARM_W | Synthesizer lead time in cycles |
| pa_level_i | input | PA_W | Requested amplifier step |
| proc_mode_o | output | 2 | 0 sleep, 1 idle, 2 active |
| afe_pwr_o | output | 1 | Analog supply on |
| prefilt_active_o | output | 1 | Prefilter active (0 = standby) |
| adc_active_o | output | 1 | Converter active (0 = shut down) |
| radio_pwr_o | output | 1 | Radio supply on |
| synth_active_o | output | 1 | RF synthesizer active (0 = standby) |
| tx_en_o | output | 1 | Transmitter on |
| rx_en_o | output | 1 | Receiver on |
| pa_level_o | output | PA_W | Amplifier step while transmitting |
| sample_strobe_o | output | 1 | One-cycle sample capture strobe |

## Verification
Every output is decoded from registered state, so each result appears on the cycle after the clock edge that samples its cause. That holds for a tick and its strobe, an acknowledge and the idle mode, comp_done_i and the warm-up, tx_done_i or abort_i and sleep. The bench drives inputs just after a falling edge and reads the outputs at the next falling edge, one rising edge later. The warm-up is counted edge by edge, so the transmitter must stay off for exactly N such samples and be on at the one after. The per-sample checks also confirm that gathering has not ended before the last tick.

// File: rtl/snpm_pkg.sv
package snpm_pkg;

    typedef enum logic [1:0] {
        PROC_SLEEP  = 2'd0,
        PROC_IDLE   = 2'd1,
        PROC_ACTIVE = 2'd2
    } proc_mode_e;

    typedef enum logic [2:0] {
        PH_REST = 3'd0,
        PH_ACQ  = 3'd1,
        PH_CALC = 3'd2,
        PH_WARM = 3'd3,
        PH_SEND = 3'd4
    } phase_e;

    typedef struct packed {
        proc_mode_e proc;
        logic       afe_pwr;
        logic       prefilt_act;
        logic       adc_act;
        logic       radio_pwr;
        logic       synth_act;
        logic       tx_en;
        logic       rx_en;
    } node_modes_t;

    function automatic node_modes_t modes_for(input phase_e ph, input logic busy);
        node_modes_t m;
        m = '{proc: PROC_SLEEP, default: 1'b0};
        case (ph)
            PH_ACQ: begin
                m.proc        = busy ? PROC_ACTIVE : PROC_IDLE;
                m.afe_pwr     = 1'b1;
                m.prefilt_act = 1'b1;
                m.adc_act     = 1'b1;
            end
            PH_CALC: m.proc = PROC_ACTIVE;
            PH_WARM: begin
                m.proc      = PROC_ACTIVE;
                m.radio_pwr = 1'b1;
                m.synth_act = 1'b1;
            end
            PH_SEND: begin
                m.proc      = PROC_IDLE;
                m.radio_pwr = 1'b1;
                m.synth_act = 1'b1;
                m.tx_en     = 1'b1;
            end
            default: m.proc = PROC_SLEEP;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/snpm_acq_ctr.sv
module snpm_acq_ctr #(
    parameter int SAMPLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic acq,
    input  logic tick,
    input  logic ack,
    output logic last_o,
    output logic strobe_o,
    output logic busy_o
);
    localparam int CW = $clog2(SAMPLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

    logic [CW-1:0] cnt_q;
    logic          take;

    assign take   = acq && tick;
    assign last_o = take && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q    <= '0;
            strobe_o <= 1'b0;
            busy_o   <= 1'b0;
        end else begin
            strobe_o <= take;
            if (take) begin
                cnt_q  <= cnt_q + 1'b1;
                busy_o <= 1'b1;
            end else if (ack) begin
                busy_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/snpm_warm_timer.sv
module snpm_warm_timer #(
    parameter int WARM_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WARM_W-1:0] load_val,
    input  logic              run,
    output logic              done_o
);
    logic [WARM_W-1:0] cnt_q;

    assign done_o = (cnt_q <= WARM_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/snpm_mode_decode.sv
module snpm_mode_decode
    import snpm_pkg::*;
(
    input  phase_e      phase,
    input  logic        busy,
    output node_modes_t modes
);
    always_comb modes = modes_for(phase, busy);
endmodule

// File: rtl/node_power_seq.sv
module node_power_seq
    import snpm_pkg::*;
#(
    parameter int SAMPLES   = 1024,
    parameter int WARM_W    = 8,
    parameter int PA_LEVELS = 6,
    localparam int PA_W     = $clog2(PA_LEVELS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wake_i,
    input  logic              abort_i,
    input  logic              tick_i,
    input  logic              svc_ack_i,
    input  logic              comp_done_i,
    input  logic              tx_done_i,
    input  logic [WARM_W-1:0] warm_cycles_i,
    input  logic [PA_W-1:0]   pa_level_i,
    output logic [1:0]        proc_mode_o,
    output logic              afe_pwr_o,
    output logic              prefilt_active_o,
    output logic              adc_active_o,
    output logic              radio_pwr_o,
    output logic              synth_active_o,
    output logic              tx_en_o,
    output logic              rx_en_o,
    output logic [PA_W-1:0]   pa_level_o,
    output logic              sample_strobe_o
);
    localparam logic [PA_W-1:0] PA_TOP = PA_W'(PA_LEVELS - 1);

    phase_e          phase_q;
    logic [PA_W-1:0] pa_q;
    logic            acq_last;
    logic            acq_busy;
    logic            warm_done;
    logic            calc_exit;
    node_modes_t     modes;

    assign calc_exit = (phase_q == PH_CALC) && comp_done_i;

    snpm_acq_ctr #(.SAMPLES(SAMPLES)) u_acq (
        .clk      (clk),
        .rst      (rst),
        .clear    (abort_i || (phase_q != PH_ACQ)),
        .acq      (phase_q == PH_ACQ),
        .tick     (tick_i),
        .ack      (svc_ack_i),
        .last_o   (acq_last),
        .strobe_o (sample_strobe_o),
        .busy_o   (acq_busy)
    );

    snpm_warm_timer #(.WARM_W(WARM_W)) u_warm (
        .clk      (clk),
        .rst      (rst),
        .load     (calc_exit),
        .load_val (warm_cycles_i),
        .run      (phase_q == PH_WARM),
        .done_o   (warm_done)
    );

    snpm_mode_decode u_dec (
        .phase (phase_q),
        .busy  (acq_busy),
        .modes (modes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_REST;
            pa_q    <= '0;
        end else if (abort_i) begin
            phase_q <= PH_REST;
        end else begin
            case (phase_q)
                PH_REST: if (wake_i) phase_q <= PH_ACQ;
                PH_ACQ:  if (acq_last) phase_q <= PH_CALC;
                PH_CALC: if (comp_done_i) begin
                    phase_q <= (warm_cycles_i == '0) ? PH_SEND : PH_WARM;
                    pa_q    <= (pa_level_i > PA_TOP) ? PA_TOP : pa_level_i;
                end
                PH_WARM: if (warm_done) phase_q <= PH_SEND;
                PH_SEND: if (tx_done_i) phase_q <= PH_REST;
                default: phase_q <= PH_REST;
            endcase
        end
    end

    assign proc_mode_o      = modes.proc;
    assign afe_pwr_o        = modes.afe_pwr;
    assign prefilt_active_o = modes.prefilt_act;
    assign adc_active_o     = modes.adc_act;
    assign radio_pwr_o      = modes.radio_pwr;
    assign synth_active_o   = modes.synth_act;
    assign tx_en_o          = modes.tx_en;
    assign rx_en_o          = modes.rx_en;
    assign pa_level_o       = (phase_q == PH_SEND) ? pa_q : '0;
endmodule

// File: rtl/snpm_checker.sv
module snpm_checker #(
    parameter int PA_LEVELS = 6,
    localparam int PA_W     = $clog2(PA_LEVELS)
) (
    input logic            clk,
    input logic            rst,
    input logic            wake_i,
    input logic            abort_i,
    input logic [1:0]      proc_mode_o,
    input logic            afe_pwr_o,
    input logic            radio_pwr_o,
    input logic            synth_active_o,
    input logic            tx_en_o,
    input logic            rx_en_o,
    input logic [PA_W-1:0] pa_level_o,
    input logic            sample_strobe_o
);
    a_r10_abort_sleeps: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> (proc_mode_o == 2'd0) && !afe_pwr_o && !radio_pwr_o && !tx_en_o && !sample_strobe_o);

    a_r11_rx_off: assert property (@(posedge clk) disable iff (rst) !rx_en_o);

    a_r3_strobe_active: assert property (@(posedge clk) disable iff (rst)
        sample_strobe_o |-> (proc_mode_o == 2'd2));

    a_r8_tx_needs_synth: assert property (@(posedge clk) disable iff (rst)
        tx_en_o |-> (synth_active_o && radio_pwr_o));

    a_r8_pa_range: assert property (@(posedge clk) disable iff (rst)
        pa_level_o <= PA_W'(PA_LEVELS - 1));

    a_r6_no_strobe_asleep: assert property (@(posedge clk) disable iff (rst)
        ((proc_mode_o == 2'd0) && !wake_i) |=> !sample_strobe_o);
endmodule

bind node_power_seq snpm_checker #(.PA_LEVELS(PA_LEVELS)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .wake_i          (wake_i),
    .abort_i         (abort_i),
    .proc_mode_o     (proc_mode_o),
    .afe_pwr_o       (afe_pwr_o),
    .radio_pwr_o     (radio_pwr_o),
    .synth_active_o  (synth_active_o),
    .tx_en_o         (tx_en_o),
    .rx_en_o         (rx_en_o),
    .pa_level_o      (pa_level_o),
    .sample_strobe_o (sample_strobe_o)
);

// File: tb/node_power_seq_tb.sv
`timescale 1ns/1ps
module node_power_seq_tb;
    localparam int SAMPLES = 1024;
    localparam int WARM_W  = 8;
    localparam int PA_W    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wake_i = 0, abort_i = 0, tick_i = 0, svc_ack_i = 0, comp_done_i = 0, tx_done_i = 0;
    logic [WARM_W-1:0] warm_cycles_i = '0;
    logic [PA_W-1:0]   pa_level_i = '0;
    logic [1:0] proc_mode_o;
    logic afe_pwr_o, prefilt_active_o, adc_active_o, radio_pwr_o, synth_active_o;
    logic tx_en_o, rx_en_o, sample_strobe_o;
    logic [PA_W-1:0] pa_level_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    node_power_seq u_dut (
        .clk(clk), .rst(rst), .wake_i(wake_i), .abort_i(abort_i), .tick_i(tick_i),
        .svc_ack_i(svc_ack_i), .comp_done_i(comp_done_i), .tx_done_i(tx_done_i),
        .warm_cycles_i(warm_cycles_i), .pa_level_i(pa_level_i),
        .proc_mode_o(proc_mode_o), .afe_pwr_o(afe_pwr_o), .prefilt_active_o(prefilt_active_o),
        .adc_active_o(adc_active_o), .radio_pwr_o(radio_pwr_o), .synth_active_o(synth_active_o),
        .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .pa_level_o(pa_level_o),
        .sample_strobe_o(sample_strobe_o)
    );

    // phase codes of the bench model: 0 sleep, 1 gather, 2 work, 3 warm-up, 4 transmit
    function automatic logic [8:0] exp_vec(input int ph, input bit busy);
        case (ph)
            1:       return {(busy ? 2'd2 : 2'd1), 7'b1110000};
            2:       return {2'd2, 7'b0000000};
            3:       return {2'd2, 7'b0001100};
            4:       return {2'd1, 7'b0001110};
            default: return {2'd0, 7'b0000000};
        endcase
    endfunction

    function automatic int clamp_pa(input int l);
        return (l > 5) ? 5 : l;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_modes(input string req, input int ph, input bit busy);
        check(req, int'({proc_mode_o, afe_pwr_o, prefilt_active_o, adc_active_o,
                         radio_pwr_o, synth_active_o, tx_en_o, rx_en_o}), int'(exp_vec(ph, busy)));
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // returns 1 when the round was aborted during gathering
    task automatic gather(input int abort_after, output bit aborted);
        aborted = 0;
        wake_i = 1; step(); wake_i = 0;
        check_modes("R2 gather start", 1, 0);
        check("R2 pa off", int'(pa_level_o), 0);
        for (int i = 0; i < SAMPLES; i++) begin
            int gap;
            gap = $urandom_range(0, 2);
            repeat (gap) step();
            tick_i = 1; step(); tick_i = 0;
            check("R3 strobe", int'(sample_strobe_o), 1);
            if (i == SAMPLES - 1) begin
                check_modes("R5 work after last tick", 2, 0);
            end else begin
                check_modes("R3 active on tick", 1, 1);
            end
            if (abort_after == i + 1) begin
                abort_i = 1; step(); abort_i = 0;
                check_modes("R10 abort", 0, 0);
                check("R10 strobe", int'(sample_strobe_o), 0);
                aborted = 1;
                return;
            end
            if (i < SAMPLES - 1) begin
                int d;
                d = $urandom_range(0, 2);
                repeat (d) step();
                svc_ack_i = 1; step(); svc_ack_i = 0;
                check_modes("R4 idle after ack", 1, 0);
            end
        end
    endtask

    task automatic finish_round(input int warm, input int pa, input int hold);
        tick_i = 1; step(); tick_i = 0;
        check("R6 tick in work", int'(sample_strobe_o), 0);
        check_modes("R5 work held", 2, 0);
        wake_i = 1; step(); wake_i = 0;
        check_modes("R2 wake ignored", 2, 0);
        warm_cycles_i = WARM_W'(warm);
        pa_level_i = PA_W'(pa);
        comp_done_i = 1; step(); comp_done_i = 0;
        for (int k = 0; k < warm; k++) begin
            check_modes("R7 warm-up", 3, 0);
            check("R8 pa off in warm-up", int'(pa_level_o), 0);
            step();
        end
        check_modes("R8 transmit", 4, 0);
        check("R8 pa level", int'(pa_level_o), clamp_pa(pa));
        pa_level_i = PA_W'(pa ^ 3);
        repeat (hold) step();
        check("R8 pa latched", int'(pa_level_o), clamp_pa(pa));
        tx_done_i = 1; step(); tx_done_i = 0;
        check_modes("R9 sleep after send", 0, 0);
        check("R9 pa off", int'(pa_level_o), 0);
        tick_i = 1; step(); tick_i = 0;
        check("R6 tick asleep", int'(sample_strobe_o), 0);
        check_modes("R1 still asleep", 0, 0);
    endtask

    initial begin
        bit ab;
        void'($urandom(32'h5EED));
        repeat (3) step();
        rst = 0;
        step();
        check_modes("R1 reset", 0, 0);
        check("R1 pa reset", int'(pa_level_o), 0);
        check("R1 strobe reset", int'(sample_strobe_o), 0);
        check("R11 rx", int'(rx_en_o), 0);

        gather(0, ab);
        finish_round(5, 3, 4);

        gather(10, ab);
        check("R10 aborted", int'(ab), 1);
        gather(0, ab);
        finish_round(0, 7, 2);

        gather(0, ab);
        finish_round($urandom_range(1, 20), $urandom_range(0, 7), $urandom_range(1, 6));

        wake_i = 1; step(); wake_i = 0;
        abort_i = 1; step(); abort_i = 0;
        check_modes("R10 abort at gather start", 0, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule